// File: doc/BRIEF.md
# Interrupt Flag Controller with Overflow Timer

This block gathers interrupt events for a small single-issue core. Three sources feed it: an edge on an external pin with selectable polarity, the wrap of an 8-bit timer with a power-of-two prescaler, and an event strobe from a serial link. Each event latches its own flag. A combined control register holds the flags together with one enable bit per source. A global enable bit sits above that register.

When the global enable is set and at least one source has both its flag and its enable set, the block starts an entry sequence of fixed length. On the first edge of that sequence it clears the global enable. On the same edge it copies the core's working register, status register and current instruction address into shadow registers, which the core reads back on return. A return-from-interrupt strobe sets the global enable back to the value it held before entry. The core's pipeline flush and the serial link logic are outside this block; each connects through a single signal.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the timer reads 0, the global enable is 0, and entry_o, vector_o and irq_req_o are all 0.
- R2: The external pin passes through two synchronizer flops before edge detection. With edge_rise_i=1 a rising pin edge sets the external flag, and with edge_rise_i=0 a falling edge sets it. The flag is visible after the third clock edge following the pin change. An edge of the opposite polarity sets nothing.
- R3: While tmr_en_i=1 the timer advances once every 2^tmr_ps_i clocks (tmr_ps_i from 0 to 7). While tmr_en_i=0 both the timer and the prescaler hold. A wrap from 0xFF to 0x00 sets the timer flag on the same edge.
- R4: A one-cycle ser_evt_i pulse sets the serial flag on the next clock edge.
- R5: Flags are set whatever the state of the per-source enables and the global enable. Without all three conditions (global enable, flag and matching enable), irq_req_o stays 0 and no entry sequence starts.
- R6: The control register layout is: bit7 external enable, bit6 timer enable, bit5 serial enable, bit3 external flag, bit2 timer flag, bit1 serial flag. Bits 4 and 0 read 0.
- R7: A control register write replaces the enables and the flags. An event in the same cycle still sets its flag.
- R8: irq_req_o is 1 when the global enable is 1 and any source has both its flag and its enable set. The clock edge that follows starts the entry sequence. entry_o is then high for exactly 3 cycles, and vector_o is high only in the third of them.
- R9: On the edge that starts entry, the global enable goes to 0 and wreg_i, status_i and pc_i are captured into the shadow outputs. Those outputs keep their values until the next entry.
- R10: A retfie_i pulse outside an entry sequence sets the global enable to the value it held just before the last entry.
- R11: A timer write loads tmr_wdata_i and clears the prescaler, so the first increment after the write comes exactly 2^tmr_ps_i clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| edge_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| ser_evt_i | input | 1 | Serial link event strobe |
| tmr_en_i | input | 1 | Timer run enable |
| tmr_ps_i | input | 3 | Prescaler exponent n, divide by 2^n |
| tmr_we_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | 8 | Timer write data |
| tmr_o | output | 8 | Timer value |
| icr_we_i | input | 1 | Control register write strobe |
| icr_wdata_i | input | 8 | Control register write data |
| icr_o | output | 8 | Control register read value |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_wdata_i | input | 1 | Global enable write data |
| gie_o | output | 1 | Global enable |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| wreg_i | input | 8 | Core working register |
| status_i | input | 8 | Core status register |
| pc_i | input | 11 | Address of first executable instruction |
| irq_req_o | output | 1 | Interrupt request condition |
| entry_o | output | 1 | Entry sequence in progress |
| vector_o | output | 1 | Last entry cycle; handler fetch follows |
| wreg_sh_o | output | 8 | Working register shadow |
| status_sh_o | output | 8 | Status register shadow |
| pc_sh_o | output | 11 | Captured instruction address |

## Verification
The assertions assume that retfie_i and the global enable write are never strobed during an entry sequence, and that the serial strobe is one cycle wide. They also assume the external pin changes no more than once per cycle. The stimulus changes every input one time unit after a rising edge. It raises each strobe for a single cycle and sends retfie_i only after entry_o has dropped. Before each return it clears the pending flag, so the request cannot re-enter at once.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PC_W     = 11;
  localparam int unsigned NSRC     = 3;
  // source index inside the flag/enable vectors
  localparam int unsigned SRC_SER  = 0;
  localparam int unsigned SRC_TMR  = 1;
  localparam int unsigned SRC_EXT  = 2;
  localparam int unsigned ENTRY_CYC = 3;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  logic cur, prev;
  assign cur  = sh_q[SYNC_STAGES-1];
  assign prev = sh_q[SYNC_STAGES];
  assign evt_o = rise_sel_i ? (cur & ~prev) : (~cur & prev);

  p_edge_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && $stable(rise_sel_i)) |=> !evt_o);
endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int unsigned TMR_W = 8,
  parameter int unsigned PS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             we_i,
  input  logic [TMR_W-1:0] wdata_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             ovf_o
);
  localparam int unsigned PSC_W = (1 << PS_W) - 1;

  logic [PSC_W-1:0] psc_q, mask;
  logic [TMR_W-1:0] tmr_q;
  logic tick;

  assign mask  = ~({PSC_W{1'b1}} << ps_i);
  assign tick  = en_i && !we_i && (psc_q == mask);
  assign ovf_o = tick && (tmr_q == {TMR_W{1'b1}});
  assign tmr_o = tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      tmr_q <= '0;
    end else if (we_i) begin
      psc_q <= '0;
      tmr_q <= wdata_i;
    end else if (tick) begin
      psc_q <= '0;
      tmr_q <= tmr_q + 1'b1;
    end else if (en_i) begin
      psc_q <= psc_q + 1'b1;
    end
  end

  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (tmr_q == '0));
  p_hold_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !we_i) |=> $stable(tmr_q));
  p_write_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (tmr_q == $past(wdata_i)));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              retfie_i,
  input  logic              gie_we_i,
  input  logic              gie_wdata_i,
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              gie_o,
  output logic              entry_o,
  output logic              vector_o,
  output logic [DATA_W-1:0] wreg_sh_o,
  output logic [DATA_W-1:0] status_sh_o,
  output logic [PC_W-1:0]   pc_sh_o
);
  localparam int unsigned CNT_W = $clog2(ENTRY_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_CYC - 1);

  logic active_q, gie_q, gie_sv_q, start;
  logic [CNT_W-1:0] cnt_q;

  assign start    = !active_q && gie_q && req_i;
  assign entry_o  = active_q;
  assign vector_o = active_q && (cnt_q == LAST);
  assign gie_o    = gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) active_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // entry beats return, return beats software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q    <= 1'b0;
      gie_sv_q <= 1'b0;
    end else if (start) begin
      gie_sv_q <= gie_q;
      gie_q    <= 1'b0;
    end else if (!active_q && retfie_i) begin
      gie_q <= gie_sv_q;
    end else if (!active_q && gie_we_i) begin
      gie_q <= gie_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wreg_sh_o   <= '0;
      status_sh_o <= '0;
      pc_sh_o     <= '0;
    end else if (start) begin
      wreg_sh_o   <= wreg_i;
      status_sh_o <= status_i;
      pc_sh_o     <= pc_i;
    end
  end

  p_gie_off_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> !gie_o);
  p_start_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(entry_o) |-> $past(req_i && gie_o));
  p_entry_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(entry_o) |=> entry_o ##1 (entry_o && vector_o) ##1 !entry_o);
  p_shadow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> ($stable(wreg_sh_o) && $stable(pc_sh_o)));
  p_retfie_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retfie_i && !entry_o && !start) |=> (gie_o == gie_sv_q));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned TMR_W = 8,
  parameter int unsigned PS_W  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pin_i,
  input  logic              edge_rise_i,
  input  logic              ser_evt_i,
  input  logic              tmr_en_i,
  input  logic [PS_W-1:0]   tmr_ps_i,
  input  logic              tmr_we_i,
  input  logic [TMR_W-1:0]  tmr_wdata_i,
  output logic [TMR_W-1:0]  tmr_o,
  input  logic              icr_we_i,
  input  logic [DATA_W-1:0] icr_wdata_i,
  output logic [DATA_W-1:0] icr_o,
  input  logic              gie_we_i,
  input  logic              gie_wdata_i,
  output logic              gie_o,
  input  logic              retfie_i,
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              irq_req_o,
  output logic              entry_o,
  output logic              vector_o,
  output logic [DATA_W-1:0] wreg_sh_o,
  output logic [DATA_W-1:0] status_sh_o,
  output logic [PC_W-1:0]   pc_sh_o
);
  logic [NSRC-1:0] evt, flag_q, en_q;
  logic ext_evt, ovf_evt, req;

  irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .rise_sel_i(edge_rise_i), .evt_o(ext_evt)
  );

  irq_timer #(.TMR_W(TMR_W), .PS_W(PS_W)) u_tmr (
    .clk_i, .rst_ni, .en_i(tmr_en_i), .ps_i(tmr_ps_i), .we_i(tmr_we_i),
    .wdata_i(tmr_wdata_i), .tmr_o, .ovf_o(ovf_evt)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_EXT] = ext_evt;
    evt[SRC_TMR] = ovf_evt;
    evt[SRC_SER] = ser_evt_i;
  end

  // hardware set wins over a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      if (icr_we_i) en_q <= icr_wdata_i[7:5];
      flag_q <= (icr_we_i ? icr_wdata_i[3:1] : flag_q) | evt;
    end
  end

  assign icr_o = {en_q, 1'b0, flag_q, 1'b0};
  assign req   = |(flag_q & en_q);

  irq_seq u_seq (
    .clk_i, .rst_ni, .req_i(req), .retfie_i, .gie_we_i, .gie_wdata_i,
    .wreg_i, .status_i, .pc_i, .gie_o, .entry_o, .vector_o,
    .wreg_sh_o, .status_sh_o, .pc_sh_o
  );

  assign irq_req_o = req && gie_o;

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt)));
  p_no_req_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && !entry_o) |=> !entry_o);
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ext_pin_i = 0, edge_rise_i = 1, ser_evt_i = 0, tmr_en_i = 0;
  logic [2:0] tmr_ps_i = '0;
  logic tmr_we_i = 0, icr_we_i = 0, gie_we_i = 0, gie_wdata_i = 0, retfie_i = 0;
  logic [7:0] tmr_wdata_i = '0, icr_wdata_i = '0, wreg_i = '0, status_i = '0;
  logic [10:0] pc_i = '0;
  logic [7:0] tmr_o, icr_o, wreg_sh_o, status_sh_o;
  logic [10:0] pc_sh_o;
  logic gie_o, irq_req_o, entry_o, vector_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_ctrl u0 (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic icr_wr(input logic [7:0] v);
    icr_we_i = 1; icr_wdata_i = v; step(1); icr_we_i = 0;
  endtask

  task automatic tmr_wr(input logic [7:0] v);
    tmr_we_i = 1; tmr_wdata_i = v; step(1); tmr_we_i = 0;
  endtask

  initial begin
    logic [7:0] held;
    step(2);
    rst_ni = 1;
    step(1);
    chk("R1 icr", icr_o, 0); chk("R1 tmr", tmr_o, 0); chk("R1 gie", gie_o, 0);
    chk("R1 entry", {entry_o, vector_o, irq_req_o}, 0);

    // R3 prescaler sweep, expected count = edges >> n
    for (int ps = 0; ps < 8; ps++) begin
      tmr_ps_i = 3'(ps); tmr_en_i = 1;
      tmr_wr(8'h00);
      step(300);
      chk($sformatf("R3 ps=%0d", ps), tmr_o, (300 >> ps) & 255);
    end
    tmr_en_i = 0; held = tmr_o;
    step(20);
    chk("R3 hold when disabled", tmr_o, held);

    // R11 write clears prescaler
    icr_wr(8'h00);
    tmr_ps_i = 3; tmr_en_i = 1;
    tmr_wr(8'h00); step(5);
    tmr_wr(8'h10); step(7);
    chk("R11 before 8 edges", tmr_o, 8'h10);
    step(1);
    chk("R11 at 8 edges", tmr_o, 8'h11);

    // R3 wrap sets timer flag (bit2)
    tmr_en_i = 0; icr_wr(8'h00);
    tmr_ps_i = 0; tmr_en_i = 1;
    tmr_wr(8'hFF);
    chk("R3 loaded FF", tmr_o, 8'hFF);
    chk("R3 no flag yet", icr_o, 8'h00);
    step(1);
    chk("R3 wrap value", tmr_o, 0);
    chk("R3 timer flag bit2", icr_o, 8'h04);
    tmr_en_i = 0; icr_wr(8'h00);

    // R2 rising edge select
    edge_rise_i = 1; ext_pin_i = 1;
    step(2); chk("R2 not before 3rd edge", icr_o, 0);
    step(1); chk("R2 rise flag bit3", icr_o, 8'h08);
    icr_wr(8'h00);
    ext_pin_i = 0; step(5);
    chk("R2 fall ignored when rise selected", icr_o, 0);
    edge_rise_i = 0; ext_pin_i = 1; step(5);
    chk("R2 rise ignored when fall selected", icr_o, 0);
    ext_pin_i = 0; step(3);
    chk("R2 fall flag bit3", icr_o, 8'h08);
    icr_wr(8'h00);

    // R4 / R6 serial flag in bit1, enables in 7..5
    ser_evt_i = 1; step(1); ser_evt_i = 0;
    chk("R4 serial flag bit1", icr_o, 8'h02);
    icr_wr(8'hFF);
    chk("R6 layout with all ones written", icr_o, 8'hEE);

    // R7 clear write collides with serial event
    icr_we_i = 1; icr_wdata_i = 8'h00; ser_evt_i = 1; step(1);
    icr_we_i = 0; ser_evt_i = 0;
    chk("R7 event beats clear", icr_o, 8'h02);
    icr_wr(8'h00);

    // R5 flags latch with enables off, no request
    gie_we_i = 1; gie_wdata_i = 1; step(1); gie_we_i = 0;
    ser_evt_i = 1; step(1); ser_evt_i = 0;
    chk("R5 flag without enable", icr_o, 8'h02);
    chk("R5 no req without enable", irq_req_o, 0);
    step(3); chk("R5 no entry without enable", entry_o, 0);
    gie_we_i = 1; gie_wdata_i = 0; step(1); gie_we_i = 0;
    icr_wr(8'h22);
    chk("R5 no req with gie off", irq_req_o, 0);
    step(3); chk("R5 no entry with gie off", entry_o, 0);
    icr_wr(8'h00);

    // R8 / R9 entry
    icr_we_i = 1; icr_wdata_i = 8'h20; gie_we_i = 1; gie_wdata_i = 1; step(1);
    icr_we_i = 0; gie_we_i = 0;
    chk("R8 no req before flag", irq_req_o, 0);
    ser_evt_i = 1; wreg_i = 8'hA5; status_i = 8'h3C; pc_i = 11'h2B7; step(1);
    ser_evt_i = 0;
    chk("R8 req raised", irq_req_o, 1);
    chk("R8 entry not yet", entry_o, 0);
    step(1);
    chk("R8 entry cycle 1", {entry_o, vector_o}, 2'b10);
    chk("R9 gie cleared", gie_o, 0);
    chk("R9 wreg shadow", wreg_sh_o, 8'hA5);
    chk("R9 status shadow", status_sh_o, 8'h3C);
    chk("R9 pc capture", pc_sh_o, 11'h2B7);
    wreg_i = 8'h00; status_i = 8'h00; pc_i = 11'h000;
    step(1); chk("R8 entry cycle 2", {entry_o, vector_o}, 2'b10);
    step(1); chk("R8 entry cycle 3", {entry_o, vector_o}, 2'b11);
    step(1); chk("R8 entry over", {entry_o, vector_o}, 2'b00);
    chk("R9 shadow kept", {wreg_sh_o, status_sh_o}, 16'hA53C);
    chk("R9 pc kept", pc_sh_o, 11'h2B7);

    // R10 return restores gie
    icr_wr(8'h20);
    retfie_i = 1; step(1); retfie_i = 0;
    chk("R10 gie restored", gie_o, 1);
    step(2);
    chk("R10 no re-entry", entry_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule